// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a performance-monitor counter bank. It has one 64-bit cycle counter and a parameterised set of 32-bit event counters. Each event counter watches one strobe, chosen by software, from a vector of single-cycle event inputs. On every clock edge where the chosen strobe is high and nothing holds the counter, the counter adds one. The event strobes come straight in as primary inputs. The bank does not generate them and does not filter them.

Software reaches every register through a flat 32-bit bus with one write strobe, one byte address and combinational read data. The bank has two ways to stop counting. The global control word has a freeze-everything bit, and each event counter has its own local freeze bit. A counter's top bit going from 0 to 1 is an overflow. When all three qualifiers for that counter are on, the overflow sets the global freeze bit in hardware in the same clock, so every count stays as it was at that moment. The interrupt line is a level. It stays high while the bank is frozen and some qualifying counter still has its top bit set. Software services it by clearing that top bit and clearing the global freeze bit.

Top module: `pmon_bank`

## Requirements
- R1: Reset clears every counter and every control bit, so all registers read 0 and `irq_o` is low.
- R2: Event counter i adds exactly one on each rising edge where its selected strobe `evt_i[sel]` is high and neither freeze bit is set. The select field is bits [7:0] of the counter's control word. A select value of `NUM_EVT` or more never counts.
- R3: While global control bit 0 (freeze all) is set, no event counter and not the cycle counter advances.
- R4: Bit 9 of a counter's control word is its local freeze. It stops that counter only, and the other counters keep counting.
- R5: The cycle counter adds one every unfrozen clock. Its low word is at byte address 0x08 and its high word at 0x0C. A carry out of the low word reaches the high word in the same clock.
- R6: A write to a counter's data register loads the written value. When a write and an increment land on the same edge, the write wins.
- R7: Counter i overflows when an increment takes it from 0x7FFF_FFFF to 0x8000_0000. If global bit 1 (interrupt enable), global bit 2 (freeze on condition) and the counter's bit 8 (condition enable) are all 1, that same edge sets global bit 0. All counters then hold, and `irq_o` goes high.
- R8: An overflow with any of those three qualifier bits at 0 does not freeze the bank and does not raise `irq_o`, and counting goes on.
- R9: `irq_o` equals the logical AND of global bits 0, 1 and 2 with the OR, over all counters, of (top bit AND condition enable). Clearing the counter's top bit, or clearing the freeze bit, drops it.
- R10: When an overflow sets the freeze bit on the same edge as a software write to the global control word, the hardware set wins over the written bit 0.
- R11: Control words read back what was written. The global word is bits [2:0] and the local words are bits [9:0]. The register map is: global at 0x00, counter i control at 0x10+8i, counter i data at 0x14+8i. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT | Single-cycle event strobes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
A wrong count, select or freeze state shows up on the data register one edge after the stimulus. A read at the next falling edge therefore catches it. A fault in overflow qualification or in the hardware freeze path shows up in the same cycle. It appears as a wrong `irq_o` level and as global bit 0 in the wrong state, and after that the counters either keep counting or stay frozen when they should not. The cycle counter's carry path only shows up when the low word wraps. For that reason the bench loads it just below the wrap point on purpose.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    localparam int DATA_W      = 32;
    localparam int SEL_W       = 8;
    localparam int GCTL_ADDR   = 'h00;
    localparam int CYC_LO_ADDR = 'h08;
    localparam int CYC_HI_ADDR = 'h0C;
    localparam int SLOT_BASE   = 'h10;
    localparam int SLOT_STRIDE = 8;

    // Global control word: bit0 freeze all, bit1 irq enable, bit2 freeze on condition.
    typedef struct packed {
        logic cond_frz;
        logic irq_en;
        logic freeze_all;
    } gctl_t;

    // Local control word: bit9 freeze, bit8 condition enable, [7:0] event select.
    typedef struct packed {
        logic             freeze;
        logic             cond_en;
        logic [SEL_W-1:0] sel;
    } lctl_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_GCTL,
        RK_CYC_LO,
        RK_CYC_HI,
        RK_LCTL,
        RK_DATA
    } rkind_t;

    typedef struct packed {
        rkind_t     kind;
        logic [7:0] slot;
    } rsel_t;

    function automatic rsel_t decode_addr(input int unsigned addr, input int unsigned nctr);
        rsel_t r;
        int unsigned off;
        r.kind = RK_NONE;
        r.slot = '0;
        if (addr == GCTL_ADDR) begin
            r.kind = RK_GCTL;
        end else if (addr == CYC_LO_ADDR) begin
            r.kind = RK_CYC_LO;
        end else if (addr == CYC_HI_ADDR) begin
            r.kind = RK_CYC_HI;
        end else if (addr >= SLOT_BASE && addr < SLOT_BASE + SLOT_STRIDE * nctr
                     && addr[1:0] == 2'b00) begin
            off    = addr - SLOT_BASE;
            r.slot = 8'(off >> 3);
            r.kind = (off[2] == 1'b0) ? RK_LCTL : RK_DATA;
        end
        return r;
    endfunction

endpackage

// File: rtl/pmon_gctl.sv
module pmon_gctl
    import pmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wdata,
    input  logic       hw_freeze,
    output gctl_t      gctl_o
);

    gctl_t gctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gctl_q <= '0;
        end else begin
            if (wr_en) begin
                gctl_q <= gctl_t'(wdata);
            end
            // Hardware freeze on a qualifying overflow beats the software write.
            if (hw_freeze) begin
                gctl_q.freeze_all <= 1'b1;
            end
        end
    end

    assign gctl_o = gctl_q;

endmodule

// File: rtl/pmon_cycle.sv
module pmon_cycle
    import pmon_pkg::*;
#(
    parameter int CYC_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frz,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CYC_W-1:0]  cnt_o
);

    localparam int HI_W = CYC_W - DATA_W;

    logic [CYC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt_q[CYC_W-1:DATA_W] <= wdata[HI_W-1:0];
        end else if (!frz) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pmon_slot.sv
module pmon_slot
    import pmon_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               gfrz_i,
    input  logic               irq_en_i,
    input  logic               cond_frz_i,
    input  logic               wr_ctl_i,
    input  logic               wr_data_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output lctl_t              ctl_o,
    output logic [DATA_W-1:0]  cnt_o,
    output logic               ovf_hit_o,
    output logic               msb_qual_o
);

    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam int CTL_W = $bits(lctl_t);

    lctl_t             ctl_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_nx;
    logic              sel_ok;
    logic              hit;
    logic              inc;
    logic              wraps_top;

    assign sel_ok    = (32'(ctl_q.sel) < NUM_EVT);
    assign hit       = sel_ok && evt_i[ctl_q.sel[IDX_W-1:0]];
    assign inc       = hit && !gfrz_i && !ctl_q.freeze;
    assign cnt_nx    = cnt_q + 1'b1;
    assign wraps_top = !cnt_q[DATA_W-1] && cnt_nx[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_ctl_i) begin
            ctl_q <= lctl_t'(wdata_i[CTL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_data_i) begin
            cnt_q <= wdata_i;
        end else if (inc) begin
            cnt_q <= cnt_nx;
        end
    end

    assign ovf_hit_o  = inc && !wr_data_i && wraps_top
                        && irq_en_i && cond_frz_i && ctl_q.cond_en;
    assign msb_qual_o = cnt_q[DATA_W-1] && ctl_q.cond_en;
    assign ctl_o      = ctl_q;
    assign cnt_o      = cnt_q;

endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
    import pmon_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 16,
    parameter int ADDR_W  = 8,
    parameter int CYC_W   = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    localparam int SLOT_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    rsel_t                          rs;
    gctl_t                          gctl;
    logic                           frz_all;
    logic                           ovf_any;
    logic [CYC_W-1:0]               cyc_cnt;
    logic [NUM_CTR-1:0][DATA_W-1:0] ev_cnt;
    lctl_t [NUM_CTR-1:0]            ev_ctl;
    logic [NUM_CTR-1:0]             ev_lfrz;
    logic [NUM_CTR-1:0]             ev_ovf;
    logic [NUM_CTR-1:0]             ev_msbq;
    logic [SLOT_W-1:0]              slot_idx;

    assign rs       = decode_addr(32'(bus_addr), NUM_CTR);
    assign slot_idx = rs.slot[SLOT_W-1:0];
    assign frz_all  = gctl.freeze_all;
    assign ovf_any  = |ev_ovf;

    pmon_gctl u_gctl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr && rs.kind == RK_GCTL),
        .wdata     (bus_wdata[2:0]),
        .hw_freeze (ovf_any),
        .gctl_o    (gctl)
    );

    pmon_cycle #(.CYC_W(CYC_W)) u_cycle (
        .clk   (clk),
        .rst   (rst),
        .frz   (frz_all),
        .wr_lo (bus_wr && rs.kind == RK_CYC_LO),
        .wr_hi (bus_wr && rs.kind == RK_CYC_HI),
        .wdata (bus_wdata),
        .cnt_o (cyc_cnt)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        logic sel_me;
        assign sel_me = (rs.slot == 8'(i));

        pmon_slot #(.NUM_EVT(NUM_EVT)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .evt_i      (evt_i),
            .gfrz_i     (frz_all),
            .irq_en_i   (gctl.irq_en),
            .cond_frz_i (gctl.cond_frz),
            .wr_ctl_i   (bus_wr && rs.kind == RK_LCTL && sel_me),
            .wr_data_i  (bus_wr && rs.kind == RK_DATA && sel_me),
            .wdata_i    (bus_wdata),
            .ctl_o      (ev_ctl[i]),
            .cnt_o      (ev_cnt[i]),
            .ovf_hit_o  (ev_ovf[i]),
            .msb_qual_o (ev_msbq[i])
        );
        assign ev_lfrz[i] = ev_ctl[i].freeze;
    end

    assign irq_o = gctl.freeze_all && gctl.irq_en && gctl.cond_frz && (|ev_msbq);

    always_comb begin
        bus_rdata = '0;
        case (rs.kind)
            RK_GCTL:   bus_rdata = DATA_W'(gctl);
            RK_CYC_LO: bus_rdata = cyc_cnt[DATA_W-1:0];
            RK_CYC_HI: bus_rdata = DATA_W'(cyc_cnt[CYC_W-1:DATA_W]);
            RK_LCTL:   bus_rdata = DATA_W'(ev_ctl[slot_idx]);
            RK_DATA:   bus_rdata = ev_cnt[slot_idx];
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmon_bank_chk.sv
module pmon_bank_chk #(
    parameter int NUM_CTR = 4,
    parameter int CYC_W   = 64
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic                     irq_o,
    input logic                     frz_all,
    input logic                     ovf_any,
    input logic [CYC_W-1:0]         cyc_cnt,
    input logic [NUM_CTR-1:0][31:0] ev_cnt,
    input logic [NUM_CTR-1:0]       ev_lfrz
);

    assert_irq_only_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> frz_all);

    assert_ovf_sets_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_any |=> frz_all);

    assert_global_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (frz_all && !bus_wr) |=> ($stable(ev_cnt) && $stable(cyc_cnt)));

    assert_cycle_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!frz_all && !bus_wr) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_lchk
        assert_local_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (ev_lfrz[i] && !bus_wr) |=> $stable(ev_cnt[i]));
    end

endmodule

bind pmon_bank pmon_bank_chk #(.NUM_CTR(NUM_CTR), .CYC_W(CYC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_wr  (bus_wr),
    .irq_o   (irq_o),
    .frz_all (frz_all),
    .ovf_any (ovf_any),
    .cyc_cnt (cyc_cnt),
    .ev_cnt  (ev_cnt),
    .ev_lfrz (ev_lfrz)
);

// File: tb/pmon_bank_bench.sv
module pmon_bank_bench;

    localparam int NC = 4;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] evt = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pmon_bank #(.NUM_CTR(NC), .NUM_EVT(NE)) u_pmon_bank (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Reference state built from the requirements.
    logic [2:0]  m_g;
    logic [63:0] m_cyc;
    logic [31:0] m_cnt [NC];
    logic [7:0]  m_sel [NC];
    logic        m_ce  [NC];
    logic        m_lf  [NC];

    always @(posedge clk) begin
        if (rst) begin
            m_g   = '0;
            m_cyc = '0;
            for (int i = 0; i < NC; i++) begin
                m_cnt[i] = '0; m_sel[i] = '0; m_ce[i] = 1'b0; m_lf[i] = 1'b0;
            end
        end else begin
            logic hw;
            hw = 1'b0;
            for (int i = 0; i < NC; i++) begin
                logic inc;
                inc = !m_g[0] && !m_lf[i] && (m_sel[i] < NE) && evt[m_sel[i][3:0]];
                if (bus_wr && int'(bus_addr) == 'h14 + 8*i) begin
                    m_cnt[i] = bus_wdata;
                end else if (inc) begin
                    if (m_cnt[i] == 32'h7FFF_FFFF && m_g[1] && m_g[2] && m_ce[i]) hw = 1'b1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
                if (bus_wr && int'(bus_addr) == 'h10 + 8*i) begin
                    m_sel[i] = bus_wdata[7:0];
                    m_ce[i]  = bus_wdata[8];
                    m_lf[i]  = bus_wdata[9];
                end
            end
            if (bus_wr && bus_addr == 8'h08)      m_cyc[31:0]  = bus_wdata;
            else if (bus_wr && bus_addr == 8'h0C) m_cyc[63:32] = bus_wdata;
            else if (!m_g[0])                     m_cyc = m_cyc + 1;
            if (bus_wr && bus_addr == 8'h00) m_g = bus_wdata[2:0];
            if (hw) m_g[0] = 1'b1;
        end
    end

    function automatic logic [31:0] m_read(input int a);
        if (a == 'h00) return {29'd0, m_g};
        if (a == 'h08) return m_cyc[31:0];
        if (a == 'h0C) return m_cyc[63:32];
        for (int i = 0; i < NC; i++) begin
            if (a == 'h10 + 8*i) return {22'd0, m_lf[i], m_ce[i], m_sel[i]};
            if (a == 'h14 + 8*i) return m_cnt[i];
        end
        return '0;
    endfunction

    function automatic logic m_irq();
        logic any;
        any = 1'b0;
        for (int i = 0; i < NC; i++) any |= m_cnt[i][31] && m_ce[i];
        return (m_g == 3'b111) && any;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 'h00) return "R11 global readback";
        if (a == 'h08 || a == 'h0C) return "R5 cycle counter";
        if (a >= 'h10 && a < 'h10 + 8*NC) return (a[2] ? "R2 event count" : "R11 local readback");
        return "R11 unmapped zero";
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input int a, input string tag);
        bus_addr = 8'(a);
        #1;
        chk(tag, 64'(bus_rdata), 64'(m_read(a)));
    endtask

    task automatic rd_val(input int a, input string tag, input logic [31:0] exp);
        bus_addr = 8'(a);
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic irq_chk(input string tag);
        chk(tag, 64'(irq_o), 64'(m_irq()));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] hold_cyc;
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        // R1: everything zero after reset
        for (int a = 0; a < 'h10 + 8*NC; a += 4) rd_val(a, "R1 reset value", 32'd0);
        chk("R1 irq low", 64'(irq_o), 64'd0);

        // R7: qualifying overflow freezes the bank and raises irq
        wr('h00, 32'h6);
        wr('h10, 32'h103);
        wr('h14, 32'h7FFF_FFFE);
        evt = 16'h0008;
        step(2);
        rd_val('h14, "R7 counter at overflow", 32'h8000_0000);
        rd_val('h00, "R7 freeze bit set by hardware", 32'h7);
        chk("R7 irq high", 64'(irq_o), 64'd1);
        step(3);
        rd_val('h14, "R7 counter holds while frozen", 32'h8000_0000);
        rd_chk('h08, "R3 cycle holds while frozen");

        // R9: clearing msb drops irq, bank stays frozen
        wr('h14, 32'h0);
        chk("R9 irq low after msb clear", 64'(irq_o), 64'd0);
        rd_val('h00, "R9 still frozen", 32'h7);
        wr('h00, 32'h6);
        rd_val('h14, "R9 no count on unfreeze edge", 32'h0);
        step(1);
        rd_val('h14, "R9 counting resumes", 32'h1);

        // R10: hardware set beats software write on the same edge
        wr('h14, 32'h7FFF_FFFF);
        wr('h00, 32'h6);
        rd_val('h00, "R10 hw freeze beats write", 32'h7);
        irq_chk("R10 irq");

        // R8: unqualified overflow keeps counting
        wr('h14, 32'h7FFF_FFFE);
        wr('h00, 32'h4);
        step(3);
        rd_val('h14, "R8 counts through msb", 32'h8000_0001);
        rd_val('h00, "R8 no hardware freeze", 32'h4);
        chk("R8 irq low", 64'(irq_o), 64'd0);

        // R6: write beats increment
        wr('h14, 32'h0000_1234);
        rd_val('h14, "R6 write wins", 32'h0000_1234);

        // R4: local freeze stops only counter 1
        wr('h18, 32'h203);
        wr('h1C, 32'h55);
        step(4);
        rd_val('h1C, "R4 frozen counter holds", 32'h55);
        rd_chk('h14, "R4 neighbour keeps counting");

        // R2: out-of-range select never counts
        wr('h20, 32'h0C8);
        evt = '1;
        step(5);
        rd_val('h24, "R2 invalid select", 32'h0);
        rd_val('h20, "R11 local readback", 32'h0C8);

        // R3: global freeze stops everything; R5: carry into high word
        wr('h00, 32'h5);
        bus_addr = 8'h08; #1; hold_cyc = bus_rdata;
        step(3);
        rd_val('h08, "R3 cycle low held", hold_cyc);
        rd_chk('h14, "R3 event counter held");
        wr('h08, 32'hFFFF_FFFF);
        wr('h0C, 32'h5);
        wr('h00, 32'h0);
        step(1);
        rd_val('h08, "R5 low word wraps", 32'h0);
        rd_val('h0C, "R5 carry in same clock", 32'h6);
        rd_val('h04, "R11 unmapped zero", 32'h0);

        // Random phase against the reference state
        for (int c = 0; c < 4000; c++) begin
            int r, a;
            logic [31:0] d;
            r = int'($urandom % (4 + 2*NC));
            case (r)
                0: a = 'h00;
                1: a = 'h08;
                2: a = 'h0C;
                3: a = 'h04;
                default: a = 'h10 + 4*(r-4);
            endcase
            rd_chk(a, tag_of(a));
            irq_chk("R9 irq level");
            evt = NE'($urandom);
            r = int'($urandom % (4 + 2*NC));
            case (r)
                0: a = 'h00;
                1: a = 'h08;
                2: a = 'h0C;
                3: a = 'h04;
                default: a = 'h10 + 4*(r-4);
            endcase
            d = $urandom;
            if (a == 'h00) begin
                d = {29'd0, 3'($urandom)};
                if ($urandom % 3 != 0) d[0] = 1'b0;
            end else if (a >= 'h10 && a[2]) begin
                if ($urandom % 2) d = 32'h7FFF_FFF0 + ($urandom % 32);
            end else if (a >= 'h10) begin
                d = {22'd0, ($urandom % 5 == 0), 1'($urandom), 8'($urandom % (NE + 2))};
            end
            bus_wr    = ($urandom % 6 == 0);
            bus_addr  = 8'(a);
            bus_wdata = d;
            @(negedge clk);
            bus_wr = 1'b0;
        end
        summary();
        $finish;
    end

endmodule